// File: doc/BRIEF.md
# Compare Timer Core

A 16-bit event counter with a compare value, controlled through four 32-bit memory-mapped words. These are control/status, prescaler setup, compare value and counter value. The block counts one of two event streams. In time mode it counts a one-cycle tick strobe supplied by a companion prescaler. In pulse mode it counts edges on one of four pulse pins, after the selected pin has been polarity-corrected.

When the counter holds the compare value and an event arrives, a sticky compare flag sets. The counter then either clears or keeps running and wraps at 16 bits, depending on a policy bit. The flag feeds an interrupt line and a DMA request line, and each line has its own enable. Software clears the flag by writing a one to it, or the DMA engine clears it with an acknowledge. The prescaler word is not used inside this block. It is stored and handed out to the companion block.

Top module: `lpcmp_timer`

## Requirements
- R1: After reset all four words (offsets 0x0, 0x4, 0x8, 0xC) read 0, and `irq` and `dma_req` are low. A read returns the addressed word one cycle after `addr` is presented.
- R2: While the run bit (control bit 0) is 0, the counter and the compare flag are held at 0 and no event changes them.
- R3: With run=1 and mode bit (control bit 1) = 0, the counter (offset 0xC, bits 15:0) increments once per clock cycle in which `tick_en` is high.
- R4: With mode bit = 1 and polarity bit (control bit 3) = 0, the counter increments on each rising edge of `pulse_in[sel]`, where sel is control bits 5:4. Edges on the other pins have no effect.
- R5: With polarity bit = 1, only falling edges of the selected pin are counted. Rising edges are ignored.
- R6: An event that arrives while counter == compare (offset 0x8, bits 15:0) sets the flag (control bit 7). With the policy bit (control bit 2) = 0, the counter goes to 0 on that event.
- R7: With policy bit = 1 the counter keeps incrementing past the compare value and wraps from 0xFFFF to 0. The flag still sets on each match.
- R8: A write to offset 0x0 with bit 7 = 1 clears the flag. With bit 7 = 0 the flag keeps its value. A new match in the same cycle wins over the clear.
- R9: A one-cycle pulse on `dma_ack` clears the flag.
- R10: `irq` is high exactly while the flag and control bit 6 are both 1. `dma_req` is high exactly while the flag and control bit 8 are both 1.
- R11: A write to the compare word takes effect only while run = 0 or the flag is 1. Otherwise it is ignored.
- R12: Writes to the counter word are ignored. The prescaler word (offset 0x4, bits 6:0) reads back as written and drives `presc_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the word accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_en | input | 1 | Prescaled tick, one cycle per count in time mode |
| pulse_in | input | 4 | Synchronized, filtered pulse pins |
| dma_ack | input | 1 | DMA acknowledge, clears the flag |
| presc_cfg | output | 7 | Prescaler setup for the companion block |
| irq | output | 1 | Interrupt, flag gated by its enable |
| dma_req | output | 1 | DMA request, flag gated by its enable |

## Verification
The assertions assume that `pulse_in` and `tick_en` are already synchronous to `clk`. They also assume that `dma_ack` is a clean single-cycle strobe. The stimulus changes every input only on the falling clock edge, so each input is stable at the edge that samples it.

The edge detector keeps tracking the selected pin even while the timer is stopped. For this reason the bench changes polarity or pin selection only while the timer is stopped, and lets at least one cycle pass before setting the run bit. This keeps a reconfiguration from showing up as a counted edge.

// File: rtl/lpcmp_pkg.sv
package lpcmp_pkg;
  localparam int OFS_CTRL  = 0;
  localparam int OFS_PRESC = 4;
  localparam int OFS_CMP   = 8;
  localparam int OFS_CNT   = 12;
  localparam int PIN_SEL_W = 2;
  localparam int FLAG_BIT  = 7;

  typedef struct packed {
    logic                 dma_en;
    logic                 irq_en;
    logic [PIN_SEL_W-1:0] pin_sel;
    logic                 pol_low;
    logic                 free_run;
    logic                 pulse_mode;
    logic                 run;
  } ctrl_t;
endpackage

// File: rtl/lpcmp_regs.sv
module lpcmp_regs
  import lpcmp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int PRESC_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               flag,
  input  logic [CNT_W-1:0]   cnt,
  output ctrl_t              ctrl,
  output logic [CNT_W-1:0]   cmp,
  output logic [PRESC_W-1:0] presc,
  output logic               flag_wclr,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESC);
  localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);

  logic [8:0] ctrl_word;

  assign flag_wclr = wr_en && (addr == A_CTRL) && wdata[FLAG_BIT];
  assign ctrl_word = {ctrl.dma_en, flag, ctrl.irq_en, ctrl.pin_sel,
                      ctrl.pol_low, ctrl.free_run, ctrl.pulse_mode, ctrl.run};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '0;
      cmp   <= '0;
      presc <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: begin
          ctrl.run        <= wdata[0];
          ctrl.pulse_mode <= wdata[1];
          ctrl.free_run   <= wdata[2];
          ctrl.pol_low    <= wdata[3];
          ctrl.pin_sel    <= wdata[4 +: PIN_SEL_W];
          ctrl.irq_en     <= wdata[6];
          ctrl.dma_en     <= wdata[8];
        end
        A_PRESC: presc <= wdata[PRESC_W-1:0];
        A_CMP:   if (!ctrl.run || flag) cmp <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:  rdata <= DATA_W'(ctrl_word);
        A_PRESC: rdata <= DATA_W'(presc);
        A_CMP:   rdata <= DATA_W'(cmp);
        A_CNT:   rdata <= DATA_W'(cnt);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lpcmp_evt.sv
module lpcmp_evt #(
  parameter int NPIN  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pulse_mode,
  input  logic             pol_low,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick_en,
  input  logic [NPIN-1:0]  pins,
  output logic             evt
);
  logic act, prev_q;

  assign act = pins[sel] ^ pol_low;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= act;
  end

  assign evt = pulse_mode ? (act && !prev_q) : tick_en;
endmodule

// File: rtl/lpcmp_count.sv
module lpcmp_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             free_run,
  input  logic             evt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic hit;
  assign hit = evt && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (evt) cnt <= (hit && !free_run) ? '0 : cnt + 1'b1;
      if (hit)          flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lpcmp_timer.sv
module lpcmp_timer
  import lpcmp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int PRESC_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic               tick_en,
  input  logic [3:0]         pulse_in,
  input  logic               dma_ack,
  output logic [PRESC_W-1:0] presc_cfg,
  output logic               irq,
  output logic               dma_req
);
  localparam int NPIN = 1 << PIN_SEL_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q, cnt_q;
  logic             flag_q, flag_wclr, evt;

  lpcmp_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .flag(flag_q), .cnt(cnt_q), .ctrl(ctrl_q), .cmp(cmp_q), .presc(presc_cfg),
    .flag_wclr(flag_wclr), .rdata(rdata)
  );

  lpcmp_evt #(.NPIN(NPIN), .SEL_W(PIN_SEL_W)) u_evt (
    .clk(clk), .rst(rst), .pulse_mode(ctrl_q.pulse_mode), .pol_low(ctrl_q.pol_low),
    .sel(ctrl_q.pin_sel), .tick_en(tick_en), .pins(pulse_in), .evt(evt)
  );

  lpcmp_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .free_run(ctrl_q.free_run), .evt(evt),
    .cmp(cmp_q), .clr_req(flag_wclr || dma_ack), .cnt(cnt_q), .flag(flag_q)
  );

  assign irq     = flag_q && ctrl_q.irq_en;
  assign dma_req = flag_q && ctrl_q.dma_en;
endmodule

// File: rtl/lpcmp_timer_chk.sv
module lpcmp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             flag,
  input logic             irq,
  input logic             dma_req,
  input logic             dma_ack
);
  p_stopped_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0) && !flag);

  p_hold_no_event_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !evt) |=> $stable(cnt));

  p_flag_from_match_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(evt && (cnt == cmp)));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (run && dma_ack && !(evt && (cnt == cmp))) |=> !flag);

  p_lines_need_flag_r10: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (!irq && !dma_req));

  p_cmp_locked_r11: assert property (@(posedge clk) disable iff (rst)
    (run && !flag) |=> $stable(cmp));
endmodule

bind lpcmp_timer lpcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl_q.run), .evt(evt), .cnt(cnt_q), .cmp(cmp_q),
  .flag(flag_q), .irq(irq), .dma_req(dma_req), .dma_ack(dma_ack)
);

// File: tb/tb_lpcmp_timer.sv
`timescale 1ns/1ps
module tb_lpcmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_en = 1'b0;
  logic [3:0]  pulse_in = '0;
  logic        dma_ack = 1'b0;
  logic [6:0]  presc_cfg;
  logic        irq, dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lpcmp_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .tick_en(tick_en), .pulse_in(pulse_in), .dma_ack(dma_ack),
    .presc_cfg(presc_cfg), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse(input int pin, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_in[pin] = 1'b1;
      @(negedge clk); pulse_in[pin] = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 16; a += 4) begin
      rd(a[3:0], d);
      chk("R1 word after reset", d, 32'h0);
    end
    chk("R1 irq/dma_req after reset", {30'h0, irq, dma_req}, 32'h0);
  endtask

  task automatic t_stopped;
    logic [31:0] d;
    ticks(5);
    rd(4'hC, d);
    chk("R2 counter while stopped", d, 32'h0);
  endtask

  task automatic t_time;
    logic [31:0] d;
    wr(4'h8, 32'd100);
    wr(4'h0, 32'h1);
    ticks(7);
    rd(4'hC, d);
    chk("R3 tick count", d, 32'd7);
    wr(4'h0, 32'h0);
    rd(4'hC, d);
    chk("R2 counter cleared on stop", d, 32'h0);
  endtask

  task automatic t_match;
    logic [31:0] d;
    wr(4'h8, 32'd3);
    wr(4'h0, 32'h141);
    ticks(3);
    rd(4'hC, d);
    chk("R6 count up to compare", d, 32'd3);
    rd(4'h0, d);
    chk("R6 no flag before event at match", d, 32'h141);
    ticks(1);
    rd(4'hC, d);
    chk("R6 counter cleared on match", d, 32'h0);
    rd(4'h0, d);
    chk("R6 flag set", d, 32'h1C1);
    chk("R10 irq and dma_req on flag", {30'h0, irq, dma_req}, 32'h3);
    wr(4'h0, 32'h141);
    rd(4'h0, d);
    chk("R8 write 0 keeps flag", d, 32'h1C1);
    wr(4'h8, 32'd50);
    rd(4'h8, d);
    chk("R11 compare write with flag set", d, 32'd50);
    wr(4'h0, 32'h1C1);
    rd(4'h0, d);
    chk("R8 write 1 clears flag", d, 32'h141);
    chk("R10 irq low after clear", {31'h0, irq}, 32'h0);
    wr(4'h8, 32'd9);
    rd(4'h8, d);
    chk("R11 compare write ignored while running", d, 32'd50);
    wr(4'h0, 32'h101);
    ticks(51);
    chk("R10 irq gated off, dma_req on", {30'h0, irq, dma_req}, 32'h1);
  endtask

  task automatic t_ack;
    logic [31:0] d;
    @(negedge clk); dma_ack = 1'b1;
    @(negedge clk); dma_ack = 1'b0;
    rd(4'h0, d);
    chk("R9 ack clears flag", d, 32'h101);
    chk("R9 dma_req low after ack", {31'h0, dma_req}, 32'h0);
  endtask

  task automatic t_free;
    logic [31:0] d;
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd5);
    wr(4'h0, 32'h5);
    ticks(6);
    rd(4'hC, d);
    chk("R7 counts past compare", d, 32'd6);
    rd(4'h0, d);
    chk("R7 flag set in free-run", d, 32'h85);
    wr(4'h0, 32'h85);
    rd(4'h0, d);
    chk("R8 flag cleared", d, 32'h5);
    ticks(65536);
    rd(4'hC, d);
    chk("R7 wrap after full period", d, 32'd6);
    rd(4'h0, d);
    chk("R7 flag set again after wrap", d, 32'h85);
  endtask

  task automatic t_pulse;
    logic [31:0] d;
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd1000);
    wr(4'h0, 32'h23);
    pulse(2, 4);
    pulse(0, 3);
    pulse(1, 2);
    rd(4'hC, d);
    chk("R4 only selected pin counted", d, 32'd4);
    wr(4'h0, 32'h28);
    @(negedge clk);
    wr(4'h0, 32'h2B);
    @(negedge clk); pulse_in[2] = 1'b1;
    @(negedge clk);
    rd(4'hC, d);
    chk("R5 rising edge ignored", d, 32'd0);
    @(negedge clk); pulse_in[2] = 1'b0;
    @(negedge clk);
    rd(4'hC, d);
    chk("R5 falling edge counted", d, 32'd1);
    pulse(2, 1);
    rd(4'hC, d);
    chk("R5 second falling edge", d, 32'd2);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(4'hC, 32'h1234);
    rd(4'hC, d);
    chk("R12 counter write ignored", d, 32'd2);
    wr(4'h4, 32'h5A);
    rd(4'h4, d);
    chk("R12 prescale readback", d, 32'h5A);
    chk("R12 presc_cfg output", {25'h0, presc_cfg}, 32'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stopped();
    t_time();
    t_match();
    t_ack();
    t_free();
    t_pulse();
    t_regs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule